// File: doc/BRIEF.md
# Timed Command Sample Tagger

This block sits beside a sample stream and a register-write bus. Every write arrives with an address, a data word, a time value and a flag that says whether the time is meaningful. Writes that carry a time and target the one configured address are held in a small command queue. All other writes leave at once on an immediate write port, unchanged.

The block rebuilds the time of each sample that goes by. When a packet header says a timestamp is present, the first sample of that packet takes the header timestamp as its time. Every later sample adds a programmable tick step to the time of the sample before it. When the time of the current sample reaches or passes the time of the oldest queued command, that sample leaves with a one-bit tag. The command then leaves on a separate timed write port in the cycle the tagged sample is accepted. Logic further down the chain uses the tag to apply a register change on exactly that sample.

Samples, last and the header pass straight through with the valid/ready handshake, so the block adds no latency to the stream.

Top module: `timed_sample_tagger`

## Requirements
- R1: A write with its timed flag low, or with an address other than the tag address, appears in the same cycle on the immediate port with identical address and data.
- R2: A write with its timed flag high and the tag address equal to the configured address never appears on the immediate port. It is queued instead.
- R3: The full output is high exactly while the queue holds 2^QUEUE_LG commands. A timed write that arrives while the queue is full is discarded and never produces a tag or a timed strobe.
- R4: Header bit 125 flags a timestamp and bits 63:0 carry it. On the first sample of a packet with bit 125 set, the sample time is that timestamp. Bit 124 marks end of burst and does not affect timing.
- R5: Each accepted sample (valid and ready both high) makes the next sample's time equal to its own time plus the 16-bit tick step. A stalled sample does not advance the time.
- R6: The tag is high on a valid sample only when the queue is non-empty and the sample time is greater than or equal to the oldest queued command's time. A command whose time has already passed therefore tags the next valid sample.
- R7: When a tagged sample is accepted, the timed port strobes for that cycle with the oldest command's data and the tag address, and that command leaves the queue. Commands leave in the order they were written.
- R8: Output data, last, header and valid equal the input ones, and input ready equals output ready, in the same cycle.
- R9: Clear, like reset, empties the queue and sets the tracked time to zero and the packet state to "first sample".
- R10: A packet whose header has bit 125 clear continues counting from the time that follows the previous packet's last accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of queue and time state |
| tick_step | input | 16 | Time added per accepted sample |
| wr_stb | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_time | input | TIME_W | Time at which a timed write applies |
| wr_timed | input | 1 | Write carries a time |
| imm_stb | output | 1 | Immediate write strobe |
| imm_addr | output | ADDR_W | Immediate write address |
| imm_data | output | DATA_W | Immediate write data |
| tmd_stb | output | 1 | Timed write strobe, issued with the tagged sample |
| tmd_addr | output | ADDR_W | Timed write address (the tag address) |
| tmd_data | output | DATA_W | Timed write data |
| cmd_full | output | 1 | Command queue full |
| s_data | input | SAMP_W | Input sample |
| s_last | input | 1 | Input last sample of packet |
| s_user | input | HDR_W | Input packet header, held for the whole packet |
| s_valid | input | 1 | Input valid |
| s_ready | output | 1 | Input ready |
| m_data | output | SAMP_W | Output sample |
| m_last | output | 1 | Output last |
| m_user | output | HDR_W | Output header |
| m_valid | output | 1 | Output valid |
| m_ready | input | 1 | Output ready |
| m_tag | output | 1 | Sample tag for the oldest timed command |

## Verification
The hardest case to reach is a tag that falls on a stalled sample, combined with two commands that share one time. In that case the tag has to stay high on the stalled sample without a strobe. It must then move to the very next sample for the second command, because that command is already late. The bench gets there by queueing two commands with equal times and withholding output ready on some samples inside a timestamped packet. It then covers the same ground with a tick step above one, with a command that is late before its packet starts, and after a clear, checking each sample against time it computes itself.

// File: rtl/tst_pkg.sv
package tst_pkg;

    // Header field positions used by the time tracker
    localparam int HDR_HAS_TS_BIT = 125;
    localparam int HDR_EOB_BIT    = 124;
    localparam int HDR_TS_W       = 64;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_IMM   = 2'd1,
        ROUTE_TIMED = 2'd2
    } route_e;

    // Sample has reached (or passed) the command time
    function automatic logic time_reached(input logic [63:0] now, input logic [63:0] due);
        return now >= due;
    endfunction

endpackage

// File: rtl/tst_write_route.sv
module tst_write_route #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int TAG_ADDR = 0
) (
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_timed,
    output tst_pkg::route_e   route,
    output logic              imm_stb,
    output logic [ADDR_W-1:0] imm_addr,
    output logic [DATA_W-1:0] imm_data
);
    import tst_pkg::*;

    localparam logic [ADDR_W-1:0] TAG_A = ADDR_W'(TAG_ADDR);

    always_comb begin
        if (!wr_stb)
            route = ROUTE_NONE;
        else if (wr_timed && (wr_addr == TAG_A))
            route = ROUTE_TIMED;
        else
            route = ROUTE_IMM;
    end

    assign imm_stb  = (route == ROUTE_IMM);
    assign imm_addr = wr_addr;
    assign imm_data = wr_data;

endmodule

// File: rtl/tst_cmd_queue.sv
module tst_cmd_queue #(
    parameter int DATA_W = 32,
    parameter int TIME_W = 64,
    parameter int LG     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TIME_W-1:0] push_time,
    input  logic              pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    output logic [TIME_W-1:0] head_time,
    output logic              full
);
    localparam int DEPTH   = 1 << LG;
    localparam int ENTRY_W = DATA_W + TIME_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [TIME_W-1:0] due;
    } entry_t;

    entry_t          mem [DEPTH];
    logic [LG-1:0]   wr_ptr, rd_ptr;
    logic [LG:0]     count;
    logic            push_ok, pop_ok;
    entry_t          head;

    assign full       = (count == (LG+1)'(DEPTH));
    assign head_valid = (count != '0);
    assign push_ok    = push && !full;
    assign pop_ok     = pop && head_valid;
    assign head       = mem[rd_ptr];
    assign head_data  = head.data;
    assign head_time  = head.due;

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= '{data: push_data, due: push_time};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // ENTRY_W kept for readers sizing the storage
    localparam int STORE_BITS = ENTRY_W * DEPTH;

endmodule

// File: rtl/tst_time_track.sv
module tst_time_track #(
    parameter int TIME_W = 64,
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              accept,
    input  logic              s_last,
    input  logic              hdr_has_ts,
    input  logic [TIME_W-1:0] hdr_ts,
    input  logic [TICK_W-1:0] tick,
    output logic [TIME_W-1:0] sample_time
);
    logic [TIME_W-1:0] next_time;
    logic              at_start;

    assign sample_time = (at_start && hdr_has_ts) ? hdr_ts : next_time;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            next_time <= '0;
            at_start  <= 1'b1;
        end else if (accept) begin
            next_time <= sample_time + TIME_W'(tick);
            at_start  <= s_last;
        end
    end

endmodule

// File: rtl/timed_sample_tagger.sv
module timed_sample_tagger #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int TIME_W   = 64,
    parameter int SAMP_W   = 32,
    parameter int HDR_W    = 128,
    parameter int QUEUE_LG = 5,
    parameter int TAG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [15:0]       tick_step,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TIME_W-1:0] wr_time,
    input  logic              wr_timed,
    output logic              imm_stb,
    output logic [ADDR_W-1:0] imm_addr,
    output logic [DATA_W-1:0] imm_data,
    output logic              tmd_stb,
    output logic [ADDR_W-1:0] tmd_addr,
    output logic [DATA_W-1:0] tmd_data,
    output logic              cmd_full,
    input  logic [SAMP_W-1:0] s_data,
    input  logic              s_last,
    input  logic [HDR_W-1:0]  s_user,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [SAMP_W-1:0] m_data,
    output logic              m_last,
    output logic [HDR_W-1:0]  m_user,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_tag
);
    import tst_pkg::*;

    route_e            route;
    logic              head_valid;
    logic [DATA_W-1:0] head_data;
    logic [TIME_W-1:0] head_time;
    logic [TIME_W-1:0] sample_time;
    logic              accept;
    logic              pop;

    tst_write_route #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .TAG_ADDR(TAG_ADDR)
    ) u_route (
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_timed(wr_timed),
        .route   (route),
        .imm_stb (imm_stb),
        .imm_addr(imm_addr),
        .imm_data(imm_data)
    );

    tst_cmd_queue #(
        .DATA_W(DATA_W),
        .TIME_W(TIME_W),
        .LG    (QUEUE_LG)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push      (route == ROUTE_TIMED),
        .push_data (wr_data),
        .push_time (wr_time),
        .pop       (pop),
        .head_valid(head_valid),
        .head_data (head_data),
        .head_time (head_time),
        .full      (cmd_full)
    );

    tst_time_track #(
        .TIME_W(TIME_W),
        .TICK_W(16)
    ) u_time (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .accept     (accept),
        .s_last     (s_last),
        .hdr_has_ts (s_user[HDR_HAS_TS_BIT]),
        .hdr_ts     (s_user[TIME_W-1:0]),
        .tick       (tick_step),
        .sample_time(sample_time)
    );

    // Stream passes straight through
    assign m_data  = s_data;
    assign m_last  = s_last;
    assign m_user  = s_user;
    assign m_valid = s_valid;
    assign s_ready = m_ready;
    assign accept  = s_valid && m_ready;

    // Compare and tag
    assign m_tag    = s_valid && head_valid &&
                      time_reached(64'(sample_time), 64'(head_time));
    assign pop      = m_tag && m_ready;
    assign tmd_stb  = pop;
    assign tmd_addr = ADDR_W'(TAG_ADDR);
    assign tmd_data = head_data;

endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
    parameter int ADDR_W   = 8,
    parameter int TAG_ADDR = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              wr_stb,
    input logic              wr_timed,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              imm_stb,
    input logic              tmd_stb,
    input logic              cmd_full,
    input logic              m_tag,
    input logic              m_valid,
    input logic              m_ready
);
    p_imm_untimed_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_timed) |-> imm_stb);

    p_timed_held_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_timed && wr_addr == ADDR_W'(TAG_ADDR)) |-> !imm_stb);

    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_full && !clr && !tmd_stb) |=> cmd_full);

    p_tag_valid_r6: assert property (@(posedge clk) disable iff (rst)
        m_tag |-> m_valid);

    p_strobe_on_tag_r7: assert property (@(posedge clk) disable iff (rst)
        tmd_stb |-> (m_tag && m_valid && m_ready));

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!cmd_full && !tmd_stb));

endmodule

bind timed_sample_tagger tst_checker #(
    .ADDR_W  (ADDR_W),
    .TAG_ADDR(TAG_ADDR)
) u_tst_checker (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .wr_stb  (wr_stb),
    .wr_timed(wr_timed),
    .wr_addr (wr_addr),
    .imm_stb (imm_stb),
    .tmd_stb (tmd_stb),
    .cmd_full(cmd_full),
    .m_tag   (m_tag),
    .m_valid (m_valid),
    .m_ready (m_ready)
);

// File: tb/test_timed_sample_tagger.sv
module test_timed_sample_tagger;
    localparam int CLK_PERIOD = 10;
    localparam int LG    = 2;
    localparam int DEPTH = 1 << LG;
    localparam int TAG   = 5;

    logic         clk = 0;
    logic         rst = 1, clr = 0;
    logic [15:0]  tick_step = 16'd1;
    logic         wr_stb = 0, wr_timed = 0;
    logic [7:0]   wr_addr = 0;
    logic [31:0]  wr_data = 0;
    logic [63:0]  wr_time = 0;
    logic         imm_stb, tmd_stb, cmd_full;
    logic [7:0]   imm_addr, tmd_addr;
    logic [31:0]  imm_data, tmd_data;
    logic [31:0]  s_data = 0, m_data;
    logic         s_last = 0, s_valid = 0, s_ready, m_last, m_valid, m_ready = 1, m_tag;
    logic [127:0] s_user = 0, m_user;

    int n_run = 0, n_fail = 0;
    logic [63:0] mtime = 0;
    bit          mfirst = 1;
    logic [63:0] qt [0:7];
    logic [31:0] qd [0:7];
    int          qn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timed_sample_tagger #(
        .QUEUE_LG(LG),
        .TAG_ADDR(TAG)
    ) i_timed_sample_tagger (
        .clk(clk), .rst(rst), .clr(clr), .tick_step(tick_step),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_time(wr_time), .wr_timed(wr_timed),
        .imm_stb(imm_stb), .imm_addr(imm_addr), .imm_data(imm_data),
        .tmd_stb(tmd_stb), .tmd_addr(tmd_addr), .tmd_data(tmd_data),
        .cmd_full(cmd_full),
        .s_data(s_data), .s_last(s_last), .s_user(s_user), .s_valid(s_valid),
        .s_ready(s_ready),
        .m_data(m_data), .m_last(m_last), .m_user(m_user), .m_valid(m_valid),
        .m_ready(m_ready), .m_tag(m_tag)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mkhdr(input bit has, input bit eob, input logic [63:0] ts);
        return {2'b00, has, eob, 60'h0, ts};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                            input logic [63:0] t, input bit h);
        bit timed;
        timed = h && (a == 8'(TAG));
        @(negedge clk);
        wr_stb = 1; wr_addr = a; wr_data = d; wr_time = t; wr_timed = h;
        #1;
        if (timed) check("R2", imm_stb, 0);
        else       check("R1", {imm_stb, imm_addr, imm_data}, {1'b1, a, d});
        @(posedge clk);
        if (timed && qn < DEPTH) begin
            qt[qn] = t; qd[qn] = d; qn++;
        end
        @(negedge clk);
        wr_stb = 0; wr_timed = 0;
        #1;
        check("R3", cmd_full, qn == DEPTH);
    endtask

    task automatic do_sample(input string req, input logic [31:0] d, input bit last,
                             input logic [127:0] hdr, input bit rdy);
        logic [63:0] st;
        bit etag;
        @(negedge clk);
        s_valid = 1; s_data = d; s_last = last; s_user = hdr; m_ready = rdy;
        #1;
        st   = (mfirst && hdr[125]) ? hdr[63:0] : mtime;
        etag = (qn > 0) && (st >= qt[0]);
        check("R8", {m_valid, m_data, m_last, s_ready}, {1'b1, d, last, rdy});
        check("R8", m_user, hdr);
        check(req, m_tag, etag);
        check("R7", tmd_stb, etag && rdy);
        if (etag && rdy) check("R7", {tmd_addr, tmd_data}, {8'(TAG), qd[0]});
        @(posedge clk);
        if (rdy) begin
            if (etag) begin
                for (int k = 0; k < 7; k++) begin qt[k] = qt[k+1]; qd[k] = qd[k+1]; end
                qn--;
            end
            mtime  = st + 64'(tick_step);
            mfirst = last;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        s_valid = 0; m_ready = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        check("R3", cmd_full, 0);
        check("R6", m_tag, 0);
        check("R7", tmd_stb, 0);
        check("R1", imm_stb, 0);

        // Routing sweep over addresses, timed and untimed
        for (int h = 0; h < 2; h++)
            for (int a = 0; a < 16; a++)
                if (!(h == 1 && a == TAG))
                    do_write(8'(a), 32'hA000 + 32'(a * 2 + h), 64'(a), bit'(h));

        // Fill the queue; the fifth timed write is dropped
        do_write(8'(TAG), 32'h11, 64'd10, 1);
        do_write(8'(TAG), 32'h22, 64'd12, 1);
        do_write(8'(TAG), 32'h33, 64'd12, 1);
        do_write(8'(TAG), 32'h44, 64'd20, 1);
        do_write(8'(TAG), 32'h55, 64'd30, 1);

        // Timestamped packet with stalls, duplicate command times
        for (int i = 0; i < 16; i++) begin
            if (i % 4 == 1 || i == 4)
                do_sample("R4", 32'(i), i == 15, mkhdr(1, 0, 64'd8), 0);
            do_sample("R4", 32'(i), i == 15, mkhdr(1, 0, 64'd8), 1);
        end
        // Untimed packet: times 24..33, the dropped command must never tag
        for (int i = 0; i < 10; i++)
            do_sample("R3", 32'(100 + i), i == 9, mkhdr(0, 1, 64'd500), 1);

        // Tick step of three
        go_idle();
        tick_step = 16'd3;
        do_write(8'(TAG), 32'h66, 64'd40, 1);
        for (int i = 0; i < 6; i++)
            do_sample("R5", 32'(200 + i), i == 5, mkhdr(0, 0, 64'd0), i != 2);

        // Late command tags the first sample of the next packet
        go_idle();
        tick_step = 16'd2;
        do_write(8'(TAG), 32'h77, 64'd50, 1);
        do_write(8'(TAG), 32'h88, 64'd107, 1);
        for (int i = 0; i < 4; i++)
            do_sample("R6", 32'(300 + i), i == 3, mkhdr(1, 1, 64'd100), 1);
        // Untimed packet continues from 108
        for (int i = 0; i < 4; i++)
            do_sample("R10", 32'(400 + i), i == 3, mkhdr(0, 0, 64'd999), 1);

        // Clear empties the queue and zeroes the time
        go_idle();
        tick_step = 16'd1;
        do_write(8'(TAG), 32'h99, 64'd1000, 1);
        do_write(8'(TAG), 32'h9A, 64'd1001, 1);
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0; #1;
        qn = 0; mtime = 0; mfirst = 1;
        check("R9", cmd_full, 0);
        do_write(8'(TAG), 32'hBB, 64'd2, 1);
        for (int i = 0; i < 5; i++)
            do_sample("R9", 32'(500 + i), i == 4, mkhdr(0, 0, 64'd777), 1);

        // Refill to full after clear
        go_idle();
        for (int i = 0; i < DEPTH + 1; i++)
            do_write(8'(TAG), 32'hC0 + 32'(i), 64'(600 + i), 1);
        check("R3", cmd_full, 1);

        go_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule